// File: doc/BRIEF.md
# Non-Blocking Cache Miss Tracker

This block sits beside a data cache's tag lookup and decides what happens to each load that reaches it. A hit passes straight through, even while fills are outstanding. A miss to a line with no outstanding fill claims a free tracking entry and sends a fill request tagged with that entry's index. A miss to a line that is already being fetched is added to that entry's list of waiting loads, and no second fill is sent. Fill responses name the entry they answer, so they may come back in any order.

When a fill comes back, the entry releases its waiting load identifiers on the wakeup port, one per cycle, oldest first. When its last load has been released, the entry is free again. A configuration input limits the tracker to one line in flight, which behaves like a cache that blocks on a second miss. In the other setting the tracker allows as many lines in flight as it has entries. A miss that cannot be accepted raises a combinational stall in the same cycle, and the stalled request has no effect.

Top module: `nbc_miss_tracker`

## Requirements
- R1: After reset all entries are free, `fill_req_valid` and `wake_valid` are 0, and `lk_stall` is 0 when no lookup is presented.
- R2: A lookup with `lk_hit`=1 never stalls and never causes a fill request, including while fills are outstanding.
- R3: A miss to a line that matches no entry takes the lowest-indexed free entry. In the next cycle `fill_req_valid` is 1, `fill_req_line` holds the line and `fill_req_tag` holds the entry index (0 to NUM_ENTRIES-1).
- R4: With `multi_miss_en`=0, a miss to a new line while any entry is busy stalls.
- R5: With `multi_miss_en`=1, up to NUM_ENTRIES different lines may be outstanding. A miss to a new line stalls once every entry is busy.
- R6: A miss to a line whose entry is still waiting for its fill joins that entry's wait list without stalling, and no fill request follows.
- R7: A miss stalls if its line's entry already holds WAIT_DEPTH loads, or if that entry's fill has already returned and the entry is still releasing loads.
- R8: A fill return with tag T wakes the loads of entry T in arrival order, one per cycle. The first `wake_valid` appears in the second cycle after the return is sampled. Returns may arrive in any order.
- R9: An entry becomes free in the cycle after its last load is woken, and a later miss can take it again.
- R10: When several entries are releasing loads, the lowest-indexed one is served each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| multi_miss_en | input | 1 | 0: one line in flight; 1: up to NUM_ENTRIES lines in flight |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_hit | input | 1 | Lookup hit in the cache |
| lk_line | input | LINE_W | Line address of the lookup |
| lk_load_id | input | ID_W | Identifier of the load |
| lk_stall | output | 1 | Miss not accepted this cycle; retry later |
| fill_req_valid | output | 1 | Fill request issued |
| fill_req_line | output | LINE_W | Line to fetch |
| fill_req_tag | output | TAG_W | Entry index carried with the fill |
| fill_ret_valid | input | 1 | Fill data returned |
| fill_ret_tag | input | TAG_W | Entry index of the returned fill |
| wake_valid | output | 1 | A waiting load is released |
| wake_load_id | output | ID_W | Identifier of the released load |

## Verification
The assertions assume that `fill_ret_tag` names only an entry that is waiting for its fill, and that `multi_miss_en` changes only while no entry is busy. The single-line limit and the busy-count checks depend on both. The stimulus returns each tag exactly once after its fill request has been seen. It switches modes only after every entry has drained. Lookups are driven for one cycle at a time and withdrawn after a stall rather than being held.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    // Life cycle of one tracking entry.
    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_PEND  = 2'd1,
        ENT_DRAIN = 2'd2
    } ent_state_e;

    // Outcome of decoding one lookup.
    typedef enum logic [2:0] {
        LK_IDLE  = 3'd0,
        LK_HIT   = 3'd1,
        LK_MERGE = 3'd2,
        LK_ALLOC = 3'd3,
        LK_STALL = 3'd4
    } lk_kind_e;

    function automatic logic is_busy(input ent_state_e s);
        return s != ENT_FREE;
    endfunction

endpackage

// File: rtl/nbc_pick_low.sv
module nbc_pick_low #(
    parameter int N   = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nbc_entry.sv
module nbc_entry
    import nbc_pkg::*;
#(
    parameter int LINE_W     = 26,
    parameter int ID_W       = 6,
    parameter int WAIT_DEPTH = 4,
    parameter int CNT_W      = $clog2(WAIT_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_i,
    input  logic              merge_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic              fill_i,
    input  logic              pop_i,
    output ent_state_e        state_o,
    output logic [LINE_W-1:0] line_o,
    output logic [ID_W-1:0]   head_o,
    output logic              full_o
);
    ent_state_e        state_q;
    logic [LINE_W-1:0] line_q;
    logic [ID_W-1:0]   ids_q [WAIT_DEPTH];
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENT_FREE;
            cnt_q   <= '0;
            line_q  <= '0;
            for (int i = 0; i < WAIT_DEPTH; i++) ids_q[i] <= '0;
        end else begin
            if (alloc_i) begin
                state_q  <= ENT_PEND;
                line_q   <= line_i;
                ids_q[0] <= id_i;
                cnt_q    <= CNT_W'(1);
            end else if (merge_i) begin
                for (int i = 0; i < WAIT_DEPTH; i++) begin
                    if (CNT_W'(i) == cnt_q) ids_q[i] <= id_i;
                end
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (pop_i) begin
                for (int i = 0; i < WAIT_DEPTH - 1; i++) ids_q[i] <= ids_q[i+1];
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) state_q <= ENT_FREE;
            end
            if (fill_i && state_q == ENT_PEND) state_q <= ENT_DRAIN;
        end
    end

    assign state_o = state_q;
    assign line_o  = line_q;
    assign head_o  = ids_q[0];
    assign full_o  = (cnt_q == CNT_W'(WAIT_DEPTH));
endmodule

// File: rtl/nbc_miss_tracker.sv
module nbc_miss_tracker
    import nbc_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int WAIT_DEPTH  = 4,
    parameter int LINE_W      = 26,
    parameter int ID_W        = 6,
    parameter int TAG_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              multi_miss_en,
    input  logic              lk_valid,
    input  logic              lk_hit,
    input  logic [LINE_W-1:0] lk_line,
    input  logic [ID_W-1:0]   lk_load_id,
    output logic              lk_stall,
    output logic              fill_req_valid,
    output logic [LINE_W-1:0] fill_req_line,
    output logic [TAG_W-1:0]  fill_req_tag,
    input  logic              fill_ret_valid,
    input  logic [TAG_W-1:0]  fill_ret_tag,
    output logic              wake_valid,
    output logic [ID_W-1:0]   wake_load_id
);
    ent_state_e        ent_state [NUM_ENTRIES];
    logic [LINE_W-1:0] ent_line  [NUM_ENTRIES];
    logic [ID_W-1:0]   ent_head  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] full_vec, free_vec, busy_vec, pend_vec, drain_vec, match_vec;
    logic [NUM_ENTRIES-1:0] alloc_gnt, drain_gnt;
    logic [TAG_W-1:0]       alloc_idx, drain_idx;
    logic                   alloc_any, drain_any;
    lk_kind_e               kind;

    nbc_pick_low #(.N(NUM_ENTRIES), .IDX_W(TAG_W)) u_alloc_pick (
        .req(free_vec), .gnt(alloc_gnt), .idx(alloc_idx), .any(alloc_any)
    );

    nbc_pick_low #(.N(NUM_ENTRIES), .IDX_W(TAG_W)) u_drain_pick (
        .req(drain_vec), .gnt(drain_gnt), .idx(drain_idx), .any(drain_any)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        nbc_entry #(
            .LINE_W(LINE_W), .ID_W(ID_W), .WAIT_DEPTH(WAIT_DEPTH)
        ) u_entry (
            .clk     (clk),
            .rst     (rst),
            .alloc_i (kind == LK_ALLOC && alloc_gnt[g]),
            .merge_i (kind == LK_MERGE && match_vec[g]),
            .line_i  (lk_line),
            .id_i    (lk_load_id),
            .fill_i  (fill_ret_valid && fill_ret_tag == TAG_W'(g)),
            .pop_i   (drain_gnt[g]),
            .state_o (ent_state[g]),
            .line_o  (ent_line[g]),
            .head_o  (ent_head[g]),
            .full_o  (full_vec[g])
        );

        assign busy_vec[g]  = is_busy(ent_state[g]);
        assign free_vec[g]  = !busy_vec[g];
        assign pend_vec[g]  = ent_state[g] == ENT_PEND;
        assign drain_vec[g] = ent_state[g] == ENT_DRAIN;
        assign match_vec[g] = busy_vec[g] && ent_line[g] == lk_line;
    end

    // Classify the lookup presented this cycle.
    always_comb begin
        if (!lk_valid)
            kind = LK_IDLE;
        else if (lk_hit)
            kind = LK_HIT;
        else if (|match_vec)
            kind = (|(match_vec & pend_vec & ~full_vec)) ? LK_MERGE : LK_STALL;
        else if (alloc_any && (multi_miss_en || !(|busy_vec)))
            kind = LK_ALLOC;
        else
            kind = LK_STALL;
    end

    assign lk_stall = (kind == LK_STALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_req_valid <= 1'b0;
            fill_req_line  <= '0;
            fill_req_tag   <= '0;
            wake_valid     <= 1'b0;
            wake_load_id   <= '0;
        end else begin
            fill_req_valid <= (kind == LK_ALLOC);
            fill_req_line  <= lk_line;
            fill_req_tag   <= alloc_idx;
            wake_valid     <= drain_any;
            wake_load_id   <= ent_head[drain_idx];
        end
    end
endmodule

// File: rtl/nbc_miss_tracker_chk.sv
module nbc_miss_tracker_chk #(
    parameter int NUM_ENTRIES = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   multi_miss_en,
    input logic                   lk_valid,
    input logic                   lk_hit,
    input logic                   lk_stall,
    input logic                   fill_req_valid,
    input logic                   wake_valid,
    input logic [NUM_ENTRIES-1:0] busy_vec,
    input logic [NUM_ENTRIES-1:0] drain_vec
);
    assert_hit_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_hit) |-> !lk_stall);

    assert_fill_after_alloc_R3: assert property (@(posedge clk) disable iff (rst)
        fill_req_valid |-> $past(lk_valid && !lk_hit && !lk_stall));

    assert_single_limit_R4: assert property (@(posedge clk) disable iff (rst)
        !multi_miss_en |-> ($countones(busy_vec) <= 1));

    assert_busy_step_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(busy_vec) <= $countones($past(busy_vec)) + 1);

    assert_stall_only_miss_R7: assert property (@(posedge clk) disable iff (rst)
        lk_stall |-> (lk_valid && !lk_hit));

    assert_wake_needs_drain_R8: assert property (@(posedge clk) disable iff (rst)
        wake_valid |-> $past(|drain_vec));
endmodule

bind nbc_miss_tracker nbc_miss_tracker_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .multi_miss_en  (multi_miss_en),
    .lk_valid       (lk_valid),
    .lk_hit         (lk_hit),
    .lk_stall       (lk_stall),
    .fill_req_valid (fill_req_valid),
    .wake_valid     (wake_valid),
    .busy_vec       (busy_vec),
    .drain_vec      (drain_vec)
);

// File: tb/nbc_miss_tracker_bench.sv
`timescale 1ns/1ps
module nbc_miss_tracker_bench;
    localparam int NE = 4;
    localparam int WD = 4;
    localparam int LW = 26;
    localparam int IW = 6;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          multi_miss_en = 1'b0;
    logic          lk_valid = 1'b0;
    logic          lk_hit = 1'b0;
    logic [LW-1:0] lk_line = '0;
    logic [IW-1:0] lk_load_id = '0;
    logic          lk_stall;
    logic          fill_req_valid;
    logic [LW-1:0] fill_req_line;
    logic [TW-1:0] fill_req_tag;
    logic          fill_ret_valid = 1'b0;
    logic [TW-1:0] fill_ret_tag = '0;
    logic          wake_valid;
    logic [IW-1:0] wake_load_id;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nbc_miss_tracker #(
        .NUM_ENTRIES(NE), .WAIT_DEPTH(WD), .LINE_W(LW), .ID_W(IW)
    ) u_nbc_miss_tracker (
        .clk(clk), .rst(rst), .multi_miss_en(multi_miss_en),
        .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_line(lk_line),
        .lk_load_id(lk_load_id), .lk_stall(lk_stall),
        .fill_req_valid(fill_req_valid), .fill_req_line(fill_req_line),
        .fill_req_tag(fill_req_tag), .fill_ret_valid(fill_ret_valid),
        .fill_ret_tag(fill_ret_tag), .wake_valid(wake_valid),
        .wake_load_id(wake_load_id)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Presents one miss for one cycle; called just after a falling edge.
    task automatic miss(input int line, input int id, input bit exp_stall,
                        input bit exp_fill, input int exp_tag, input string req);
        lk_valid = 1'b1; lk_hit = 1'b0;
        lk_line = LW'(line); lk_load_id = IW'(id);
        #1 chk({req, " stall"}, lk_stall, exp_stall);
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " fill_req_valid"}, fill_req_valid, exp_fill);
        if (exp_fill) begin
            chk({req, " fill_req_tag"}, fill_req_tag, exp_tag);
            chk({req, " fill_req_line"}, fill_req_line, line);
        end
    endtask

    task automatic hit(input int line);
        lk_valid = 1'b1; lk_hit = 1'b1; lk_line = LW'(line); lk_load_id = '0;
        #1 chk("R2 hit stall", lk_stall, 0);
        @(negedge clk);
        lk_valid = 1'b0; lk_hit = 1'b0;
        chk("R2 hit fill_req_valid", fill_req_valid, 0);
    endtask

    // Returns one fill and checks the released loads in order.
    task automatic ret_drain(input int tag, input int n, input int ids [4]);
        fill_ret_valid = 1'b1; fill_ret_tag = TW'(tag);
        @(negedge clk);
        fill_ret_valid = 1'b0;
        chk("R8 no wake in first cycle", wake_valid, 0);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("R8 wake_valid", wake_valid, 1);
            chk("R8 wake order", wake_load_id, ids[k]);
        end
        @(negedge clk);
        chk("R9 wake ends", wake_valid, 0);
    endtask

    initial begin
        int ids [4];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 stall idle", lk_stall, 0);
        chk("R1 fill_req_valid", fill_req_valid, 0);
        chk("R1 wake_valid", wake_valid, 0);
        @(negedge clk);

        // Single-line mode.
        multi_miss_en = 1'b0;
        miss('h100, 1, 0, 1, 0, "R3 first alloc");
        hit('h200);
        miss('h300, 2, 1, 0, 0, "R4 second line stalls");
        miss('h100, 3, 0, 0, 0, "R6 merge single mode");
        ids = '{1, 3, 0, 0};
        ret_drain(0, 2, ids);
        miss('h300, 4, 0, 1, 0, "R9 reuse entry 0");
        ids = '{4, 0, 0, 0};
        ret_drain(0, 1, ids);

        // Several lines in flight.
        multi_miss_en = 1'b1;
        for (int e = 0; e < NE; e++) miss('h400 + e, 8 + e, 0, 1, e, "R5 alloc");
        miss('h500, 12, 1, 0, 0, "R5 all busy stalls");
        hit('h700);
        for (int k = 1; k < WD; k++) miss('h402, 20 + k, 0, 0, 0, "R6 merge");
        miss('h402, 30, 1, 0, 0, "R7 wait list full");
        ids = '{10, 21, 22, 23};
        ret_drain(2, 4, ids);
        miss('h402, 31, 0, 1, 2, "R9 freed entry reused");
        ids = '{11, 0, 0, 0};
        ret_drain(3, 1, ids);
        ids = '{31, 0, 0, 0};
        ret_drain(2, 1, ids);
        miss('h400, 40, 0, 0, 0, "R6 merge e0");
        miss('h401, 41, 0, 0, 0, "R6 merge e1");

        // Two entries releasing together; lowest index wins.
        fill_ret_valid = 1'b1; fill_ret_tag = 2'd1;
        @(negedge clk);
        fill_ret_tag = 2'd0;
        chk("R10 no wake yet", wake_valid, 0);
        @(negedge clk);
        fill_ret_valid = 1'b0;
        chk("R10 wake 1", wake_load_id, 9);
        lk_valid = 1'b1; lk_hit = 1'b0; lk_line = LW'('h401); lk_load_id = 6'd50;
        #1 chk("R7 draining line stalls", lk_stall, 1);
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R7 stalled miss no fill", fill_req_valid, 0);
        chk("R10 wake 2", wake_load_id, 8);
        @(negedge clk);
        chk("R10 wake 3", wake_load_id, 40);
        @(negedge clk);
        chk("R10 wake 4", wake_load_id, 41);
        chk("R10 wake_valid", wake_valid, 1);
        @(negedge clk);
        chk("R10 wake ends", wake_valid, 0);

        // Sweep over wait-list length and returning entry.
        for (int n = 1; n <= WD; n++) begin
            for (int e = 0; e < NE; e++) begin
                for (int j = 0; j < NE; j++)
                    miss('h800 + j * 16, j, 0, 1, j, "R3 sweep alloc");
                for (int k = 1; k < n; k++)
                    miss('h800 + e * 16, 32 + k, 0, 0, 0, "R6 sweep merge");
                ids = '{e, 33, 34, 35};
                ret_drain(e, n, ids);
                for (int j = 0; j < NE; j++) begin
                    if (j != e) begin
                        ids = '{j, 0, 0, 0};
                        ret_drain(j, 1, ids);
                    end
                end
            end
        end

        #1 chk("R1 idle stall at end", lk_stall, 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule